// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is the control unit of a small accumulator machine, built from fixed logic rather than from a control store. It holds the machine's visible registers: program counter, memory address register, memory buffer register, instruction register, accumulator, and the two staging registers that feed and catch the adder. A two-bit cycle code tracks which phase of the instruction cycle the machine is in. A timing counter inside each phase steps through a fixed list of register transfers. The decoder turns each (cycle code, step, opcode) triple into register loads and memory strobes. Every transfer takes one clock period.

Instruction words are 12 bits by default: an indirect flag at the top bit, a 3-bit opcode below it, and an 8-bit address at the bottom. The memory port has no wait states. The address always comes from the memory address register and the write data from the buffer register. Read data is taken in the same cycle the read strobe is high, and a write happens on the clock edge that ends a cycle with the write strobe high. Two instructions do work: add-to-accumulator and branch-with-saved-return-address. Any other opcode passes straight through execution. A pending request, when enabled, diverts the machine after execution. The return address is saved at a fixed location and control goes to a fixed handler address.

Top module: `insn_cycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the design clears pc, ac and ir, sets the cycle code to 00 (fetch) and the step to 0, and keeps both memory strobes low. Interrupts start out enabled.
- R2: The cycle code is 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. After fetch the code is 01 if word bit 11 is set and 10 if it is clear. Indirect is always followed by 10.
- R3: Fetch takes three clocks. In step 0, MAR is loaded from pc. In step 1, `mem_rd` is high, MBR is loaded from memory and pc increments. In step 2, IR is loaded from MBR.
- R4: Opcode 001 (word bits 10:8) adds the memory word at the effective address to ac, modulo 2^12. This takes five execute clocks (MAR, MBR, Y, Z=ac+Y, ac=Z), so a direct add takes 8 clocks in all.
- R5: An indirect instruction (bit 11 set) spends three clocks replacing the IR address field with bits 7:0 of the word at that address. A direct add therefore takes 8 clocks and an indirect add 11.
- R6: Opcode 101 at address X writes the incremented pc to memory location X. The write strobe is high in execute step 1, with `mem_addr`=X. It then sets pc to X+1, and execution takes three clocks.
- R7: When execution ends with `irq_req` high and interrupts enabled, the code becomes 11. The interrupt cycle takes three clocks: MBR gets pc, then MAR gets SAVE_ADDR (0xF0) and pc gets ISR_ADDR (0xE0), then pc is written to SAVE_ADDR. After that the code returns to 00.
- R8: The interrupt cycle disables interrupts. A request that is still high at the end of a later execution is ignored, and the code goes to 00.
- R9: Each step lasts one clock. The step counter returns to 0 whenever the cycle code changes.
- R10: Any opcode other than 001 and 101 spends one execute clock and changes neither ac nor memory.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Interrupt request level |
| mem_rdata | input | DATA_W | Memory read data for `mem_addr` |
| mem_addr | output | ADDR_W | Memory address (MAR) |
| mem_wdata | output | DATA_W | Memory write data (MBR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc | output | ADDR_W | Program counter |
| ac | output | DATA_W | Accumulator |
| ir | output | DATA_W | Instruction register |
| cyc_code | output | 2 | Current cycle code |
| step | output | 3 | Step within the current cycle |

## Verification
The hardest state to reach is the interrupt path. A request has to be high exactly when an execution ends, and a second request after the first must be seen to do nothing. The stimulus gets there with a program that first branches with the return address saved. The return lands on an add, and the request is raised during that add. The handler then runs another add with the request still held. The bench watches the saved word in its memory model, the vectored pc, and a cycle code that returns to fetch instead of entering interrupt again.

// File: rtl/icc_pkg.sv
package icc_pkg;

   typedef enum logic [1:0] {
      CC_FETCH = 2'b00,
      CC_INDIR = 2'b01,
      CC_EXEC  = 2'b10,
      CC_INTR  = 2'b11
   } cyc_code_e;

   localparam int unsigned STEPS_MAX = 5;
   localparam int unsigned STEP_W    = $clog2(STEPS_MAX);

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_ira;
      logic mar_from_save;
      logic mbr_from_mem;
      logic mbr_from_pc;
      logic pc_inc;
      logic pc_from_ira;
      logic pc_from_isr;
      logic ir_from_mbr;
      logic ira_from_mbr;
      logic y_from_mbr;
      logic z_from_sum;
      logic ac_from_z;
      logic mem_rd;
      logic mem_wr;
      logic ie_clr;
      logic last;
   } ctl_t;

endpackage

// File: rtl/icc_decode.sv
module icc_decode
   import icc_pkg::*;
#(
   parameter int unsigned OPC_W   = 3,
   parameter int unsigned OPC_ADD = 1,
   parameter int unsigned OPC_BSA = 5
) (
   input  cyc_code_e         code,
   input  logic [STEP_W-1:0] step,
   input  logic [OPC_W-1:0]  opc,
   output ctl_t              ctl
);

   localparam logic [OPC_W-1:0] ADD_CODE = OPC_W'(OPC_ADD);
   localparam logic [OPC_W-1:0] BSA_CODE = OPC_W'(OPC_BSA);

   always_comb begin
      ctl = '0;
      unique case (code)
         CC_FETCH: begin
            case (step)
               3'd0:    ctl.mar_from_pc = 1'b1;
               3'd1: begin
                  ctl.mem_rd       = 1'b1;
                  ctl.mbr_from_mem = 1'b1;
                  ctl.pc_inc       = 1'b1;
               end
               3'd2: begin
                  ctl.ir_from_mbr = 1'b1;
                  ctl.last        = 1'b1;
               end
               default: ctl.last = 1'b1;
            endcase
         end
         CC_INDIR: begin
            case (step)
               3'd0:    ctl.mar_from_ira = 1'b1;
               3'd1: begin
                  ctl.mem_rd       = 1'b1;
                  ctl.mbr_from_mem = 1'b1;
               end
               3'd2: begin
                  ctl.ira_from_mbr = 1'b1;
                  ctl.last         = 1'b1;
               end
               default: ctl.last = 1'b1;
            endcase
         end
         CC_EXEC: begin
            if (opc == ADD_CODE) begin
               case (step)
                  3'd0:    ctl.mar_from_ira = 1'b1;
                  3'd1: begin
                     ctl.mem_rd       = 1'b1;
                     ctl.mbr_from_mem = 1'b1;
                  end
                  3'd2:    ctl.y_from_mbr = 1'b1;
                  3'd3:    ctl.z_from_sum = 1'b1;
                  3'd4: begin
                     ctl.ac_from_z = 1'b1;
                     ctl.last      = 1'b1;
                  end
                  default: ctl.last = 1'b1;
               endcase
            end else if (opc == BSA_CODE) begin
               case (step)
                  3'd0: begin
                     ctl.mar_from_ira = 1'b1;
                     ctl.mbr_from_pc  = 1'b1;
                  end
                  3'd1: begin
                     ctl.pc_from_ira = 1'b1;
                     ctl.mem_wr      = 1'b1;
                  end
                  3'd2: begin
                     ctl.pc_inc = 1'b1;
                     ctl.last   = 1'b1;
                  end
                  default: ctl.last = 1'b1;
               endcase
            end else begin
               ctl.last = 1'b1;
            end
         end
         CC_INTR: begin
            case (step)
               3'd0:    ctl.mbr_from_pc = 1'b1;
               3'd1: begin
                  ctl.mar_from_save = 1'b1;
                  ctl.pc_from_isr   = 1'b1;
               end
               3'd2: begin
                  ctl.mem_wr = 1'b1;
                  ctl.ie_clr = 1'b1;
                  ctl.last   = 1'b1;
               end
               default: ctl.last = 1'b1;
            endcase
         end
         default: ctl.last = 1'b1;
      endcase
   end

endmodule

// File: rtl/icc_sequencer.sv
module icc_sequencer
   import icc_pkg::*;
#(
   parameter bit ONEHOT_STEP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              last,
   input  logic              ind_bit,
   input  logic              irq_pend,
   output cyc_code_e         code,
   output logic [STEP_W-1:0] step
);

   cyc_code_e code_q;
   cyc_code_e code_nx;

   always_comb begin
      code_nx = code_q;
      if (last) begin
         unique case (code_q)
            CC_FETCH: code_nx = ind_bit  ? CC_INDIR : CC_EXEC;
            CC_INDIR: code_nx = CC_EXEC;
            CC_EXEC:  code_nx = irq_pend ? CC_INTR  : CC_FETCH;
            CC_INTR:  code_nx = CC_FETCH;
            default:  code_nx = CC_FETCH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) code_q <= CC_FETCH;
      else     code_q <= code_nx;
   end

   assign code = code_q;

   generate
      if (ONEHOT_STEP) begin : g_onehot
         logic [STEPS_MAX-1:0] oh_q;
         always_ff @(posedge clk) begin
            if (rst || last) oh_q <= STEPS_MAX'(1);
            else             oh_q <= {oh_q[STEPS_MAX-2:0], 1'b0};
         end
         always_comb begin
            step = '0;
            for (int k = 0; k < STEPS_MAX; k++) begin
               if (oh_q[k]) step = step | STEP_W'(k);
            end
         end
      end else begin : g_binary
         logic [STEP_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || last) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end
         assign step = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
   import icc_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SAVE_ADDR   = 'hF0,
   parameter int unsigned ISR_ADDR    = 'hE0,
   parameter bit          IE_AT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] ac,
   output logic              ie
);

   localparam int unsigned     PAD_W  = DATA_W - ADDR_W;
   localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
   localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_ADDR);

   logic [DATA_W-1:0] y_q;
   logic [DATA_W-1:0] z_q;
   logic [ADDR_W-1:0] ira;

   assign ira = ir[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mar <= '0;
         mbr <= '0;
         pc  <= '0;
         ir  <= '0;
         ac  <= '0;
         y_q <= '0;
         z_q <= '0;
         ie  <= IE_AT_RESET;
      end else begin
         if (ctl.mar_from_pc)        mar <= pc;
         else if (ctl.mar_from_ira)  mar <= ira;
         else if (ctl.mar_from_save) mar <= SAVE_A;

         if (ctl.mbr_from_mem)      mbr <= mem_rdata;
         else if (ctl.mbr_from_pc)  mbr <= {{PAD_W{1'b0}}, pc};

         if (ctl.pc_inc)            pc <= pc + 1'b1;
         else if (ctl.pc_from_ira)  pc <= ira;
         else if (ctl.pc_from_isr)  pc <= ISR_A;

         if (ctl.ir_from_mbr)       ir <= mbr;
         else if (ctl.ira_from_mbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];

         if (ctl.y_from_mbr) y_q <= mbr;
         if (ctl.z_from_sum) z_q <= ac + y_q;
         if (ctl.ac_from_z)  ac  <= z_q;
         if (ctl.ie_clr)     ie  <= 1'b0;
      end
   end

endmodule

// File: rtl/insn_cycle_ctrl.sv
module insn_cycle_ctrl
   import icc_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned OPC_W       = 3,
   parameter int unsigned OPC_ADD     = 1,
   parameter int unsigned OPC_BSA     = 5,
   parameter int unsigned SAVE_ADDR   = 'hF0,
   parameter int unsigned ISR_ADDR    = 'hE0,
   parameter bit          IE_AT_RESET = 1'b1,
   parameter bit          ONEHOT_STEP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              irq_req,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ac,
   output logic [DATA_W-1:0] ir,
   output logic [1:0]        cyc_code,
   output logic [2:0]        step
);

   localparam int unsigned IND_BIT = DATA_W - 1;
   localparam int unsigned OPC_LSB = ADDR_W;

   initial begin
      assert (DATA_W >= ADDR_W + OPC_W + 1)
         else $error("word too narrow for flag, opcode and address");
      assert (ADDR_W >= 2 && OPC_W >= 2) else $error("field widths too small");
      assert (SAVE_ADDR < (1 << ADDR_W) && ISR_ADDR < (1 << ADDR_W))
         else $error("save or handler address out of range");
      assert (OPC_ADD != OPC_BSA && OPC_ADD < (1 << OPC_W) && OPC_BSA < (1 << OPC_W))
         else $error("opcode assignment invalid");
      assert (STEP_W <= 3) else $error("step port too narrow");
   end

   ctl_t              ctl;
   cyc_code_e         code;
   logic [STEP_W-1:0] step_w;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mbr;
   logic              ie_w;

   icc_sequencer #(.ONEHOT_STEP(ONEHOT_STEP)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .last     (ctl.last),
      .ind_bit  (mbr[IND_BIT]),
      .irq_pend (irq_req & ie_w),
      .code     (code),
      .step     (step_w)
   );

   icc_decode #(.OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_BSA(OPC_BSA)) u_dec (
      .code (code),
      .step (step_w),
      .opc  (ir[OPC_LSB +: OPC_W]),
      .ctl  (ctl)
   );

   icc_datapath #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .SAVE_ADDR   (SAVE_ADDR),
      .ISR_ADDR    (ISR_ADDR),
      .IE_AT_RESET (IE_AT_RESET)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .mar       (mar),
      .mbr       (mbr),
      .pc        (pc),
      .ir        (ir),
      .ac        (ac),
      .ie        (ie_w)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign mem_rd    = ctl.mem_rd & ~rst;
   assign mem_wr    = ctl.mem_wr & ~rst;
   assign cyc_code  = code;
   assign step      = 3'(step_w);

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned ISR_ADDR = 'hE0
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] pc,
   input logic [1:0]        cyc_code,
   input logic [2:0]        step,
   input logic              ie
);

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (pc == '0 && cyc_code == 2'b00 && step == 3'd0));

   a_r3_fetch_pc_inc: assert property (@(posedge clk) disable iff (rst)
      (cyc_code == 2'b00 && step == 3'd1) |=> pc == ADDR_W'($past(pc) + 1'b1));

   a_r5_indirect_to_exec: assert property (@(posedge clk) disable iff (rst)
      (cyc_code == 2'b01 && step == 3'd2) |=> cyc_code == 2'b10);

   a_r7_isr_vector: assert property (@(posedge clk) disable iff (rst)
      (cyc_code == 2'b11 && step == 3'd1) |=> pc == ADDR_W'(ISR_ADDR));

   a_r8_ie_cleared: assert property (@(posedge clk) disable iff (rst)
      (cyc_code == 2'b11 && step == 3'd2) |=> !ie);

   a_r9_step_restart: assert property (@(posedge clk) disable iff (rst)
      !$stable(cyc_code) |-> step == 3'd0);

   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

bind insn_cycle_ctrl icc_checker #(.ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR)) u_icc_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .pc       (pc),
   .cyc_code (cyc_code),
   .step     (step),
   .ie       (ie_w)
);

// File: tb/test_insn_cycle_ctrl.sv
module test_insn_cycle_ctrl;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq_req = 1'b0;
   logic [11:0] mem_rdata;
   logic [7:0]  mem_addr;
   logic [11:0] mem_wdata;
   logic        mem_rd, mem_wr;
   logic [7:0]  pc;
   logic [11:0] ac, ir;
   logic [1:0]  cyc_code;
   logic [2:0]  step;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [11:0] mem [256];

   always #2.5 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

   insn_cycle_ctrl i_insn_cycle_ctrl (
      .clk(clk), .rst(rst), .irq_req(irq_req), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .pc(pc), .ac(ac), .ir(ir), .cyc_code(cyc_code), .step(step)
   );

   // {indirect flag, operand}
   localparam logic [12:0] ADD_VEC [6] = '{
      {1'b0, 12'h123}, {1'b1, 12'h456}, {1'b0, 12'hFFF},
      {1'b1, 12'h001}, {1'b0, 12'h800}, {1'b1, 12'h7FF}
   };

   function automatic logic [11:0] word(input logic ind, input logic [2:0] opc,
                                        input logic [7:0] a);
      return {ind, opc, a};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [11:0] exp_ac;
      for (int a = 0; a < 256; a++) mem[a] = 12'h000;
      for (int i = 0; i < 6; i++) begin
         mem[8'h40 + i] = ADD_VEC[i][11:0];
         mem[8'h50 + i] = 12'h040 + 12'(i);
         mem[i] = word(ADD_VEC[i][12], 3'b001,
                       ADD_VEC[i][12] ? 8'(8'h50 + i) : 8'(8'h40 + i));
      end
      mem[6]     = word(1'b0, 3'b000, 8'h40);   // no-op opcode
      mem[7]     = word(1'b0, 3'b101, 8'h30);   // branch saving return
      mem[8'h31] = word(1'b0, 3'b001, 8'h41);
      mem[8'hE0] = word(1'b0, 3'b001, 8'h42);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "pc", 32'(pc), 0);
      chk("R1", "ac", 32'(ac), 0);
      chk("R1", "cyc_code", 32'(cyc_code), 0);
      chk("R1", "step", 32'(step), 0);
      chk("R1", "strobes", {30'd0, mem_rd, mem_wr}, 0);
      rst = 1'b0;

      // table walk: direct and indirect adds
      exp_ac = '0;
      for (int i = 0; i < 6; i++) begin
         if (ADD_VEC[i][12]) begin
            run(3);
            chk("R2", "code after indirect fetch", 32'(cyc_code), 1);
            run(3);
            chk("R5", "code after indirect", 32'(cyc_code), 2);
            run(5);
         end else begin
            run(3);
            chk("R2", "code after direct fetch", 32'(cyc_code), 2);
            run(5);
         end
         exp_ac = exp_ac + ADD_VEC[i][11:0];
         chk(ADD_VEC[i][12] ? "R5" : "R4", "ac after add", 32'(ac), 32'(exp_ac));
         chk("R4", "pc after add", 32'(pc), i + 1);
         chk("R9", "step at next fetch", 32'(step), 0);
      end

      // no-op opcode at 6, stepped one clock at a time
      run(1);
      chk("R3", "mem_addr step1", 32'(mem_addr), 6);
      chk("R3", "mem_rd step1", 32'(mem_rd), 1);
      chk("R9", "step after 1 clk", 32'(step), 1);
      run(1);
      chk("R3", "pc after step1", 32'(pc), 7);
      chk("R9", "step after 2 clk", 32'(step), 2);
      chk("R3", "mem_rd step2", 32'(mem_rd), 0);
      run(1);
      chk("R10", "code in execute", 32'(cyc_code), 2);
      chk("R3", "ir loaded", 32'(ir), 32'(word(1'b0, 3'b000, 8'h40)));
      run(1);
      chk("R10", "single execute clock", 32'(cyc_code), 0);
      chk("R10", "ac unchanged", 32'(ac), 32'(exp_ac));
      chk("R10", "mem untouched", 32'(mem[8'h40]), 32'(ADD_VEC[0][11:0]));

      // branch with saved return at 7 to 0x30
      run(4);
      chk("R6", "mem_wr exec step1", 32'(mem_wr), 1);
      chk("R11", "mem_rd during write", 32'(mem_rd), 0);
      chk("R6", "write address", 32'(mem_addr), 32'h30);
      chk("R6", "write data", 32'(mem_wdata), 8);
      run(2);
      chk("R6", "saved return", 32'(mem[8'h30]), 8);
      chk("R6", "pc after branch", 32'(pc), 32'h31);
      chk("R6", "code after branch", 32'(cyc_code), 0);

      // add at 0x31 with request raised
      irq_req = 1'b1;
      run(8);
      exp_ac = exp_ac + mem[8'h41];
      chk("R7", "enter interrupt", 32'(cyc_code), 3);
      chk("R4", "ac before interrupt", 32'(ac), 32'(exp_ac));
      run(2);
      chk("R7", "save write strobe", 32'(mem_wr), 1);
      chk("R7", "save address", 32'(mem_addr), 32'hF0);
      chk("R7", "vector pc", 32'(pc), 32'hE0);
      run(1);
      chk("R7", "saved pc", 32'(mem[8'hF0]), 32'h32);
      chk("R7", "back to fetch", 32'(cyc_code), 0);

      // handler add with request still high: must not re-enter
      run(8);
      exp_ac = exp_ac + mem[8'h42];
      chk("R8", "no second interrupt", 32'(cyc_code), 0);
      chk("R8", "pc continues", 32'(pc), 32'hE1);
      chk("R8", "save slot unchanged", 32'(mem[8'hF0]), 32'h32);
      chk("R4", "ac in handler", 32'(ac), 32'(exp_ac));

      // synchronous reset mid-run
      run(2);
      rst = 1'b1;
      run(1);
      chk("R1", "pc after mid reset", 32'(pc), 0);
      chk("R1", "code after mid reset", 32'(cyc_code), 0);
      chk("R1", "ac after mid reset", 32'(ac), 0);
      rst = 1'b0;
      irq_req = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule